// File: doc/BRIEF.md
# Operating-System Match Timer with Watchdog

This block is a free-running 32-bit up-counter that a system uses for scheduling ticks and timeouts. The counter advances by one on each clock cycle in which the base-rate tick enable is high. Four match registers are each compared with the counter. When the counter steps onto a match value, that channel records a sticky status flag and drives its own interrupt line, but only if software has enabled that channel. Software clears a flag by writing a 1 to its status bit.

The last match channel has a second job as a one-shot watchdog. If the watchdog enable bit is set when that channel matches, the block emits a single-cycle reset request and clears the enable bit, so software has to re-arm it. The block does not reset itself. All registers sit on a simple 32-bit read/write bus addressed by byte offset. Reads return data one cycle after the request, and any access to an offset that is not mapped raises a one-cycle error flag.

Top module: `os_timer`

## Requirements
- R1: After reset, the counter, all match registers, the status register, the interrupt enable register and the watchdog enable read as zero, all interrupt outputs are low and the reset request is low.
- R2: The counter adds one on every clock edge where tick_i is high and no counter write is taking place. It wraps from 0xFFFFFFFF to 0.
- R3: A write to the counter register loads the written value at that edge and takes priority over a tick. Counting resumes from the loaded value. A load never produces a match event, even when the loaded value equals a match register.
- R4: A match event on channel N happens at the clock edge where an increment makes the counter equal to match register N. If interrupt enable bit N is 1, status bit N is set and irq_o[N] goes high at that edge. While the counter holds the same value without incrementing, no new event occurs.
- R5: A match on a channel whose interrupt enable bit is 0 leaves its status bit and its interrupt output at 0.
- R6: A write to the status register clears every status bit whose written bit is 1, and the matching irq_o bit falls. Written 0 bits, and 1 bits over flags that are already clear, leave the register unchanged.
- R7: A write to the interrupt enable register keeps bits [11:0]. Bits [31:12] always read as zero.
- R8: When channel 3 matches while watchdog enable bit 0 is 1, rst_req_o is high for exactly one cycle and the watchdog enable bit reads 0 afterwards. This happens whatever the channel's interrupt enable is. When the watchdog enable bit is 0, a match produces no request.
- R9: A read from an unmapped or misaligned offset returns zero. Any access to such an offset raises err_o for exactly one cycle, in the cycle after the access.
- R10: Register offsets are as follows. Match register n is at 4*n (0x00 to 0x0C). The counter is at 0x10. Status is at 0x14, in bits [3:0]. Watchdog enable is at 0x18, in bit 0. Interrupt enable is at 0x1C. A read captures the addressed value at the clock edge where sel_i is high, and presents it on rdata_o from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base-rate count enable |
| sel_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| err_o | output | 1 | One-cycle flag for an unmapped access |
| irq_o | output | 4 | Per-channel interrupt, mirrors the status bits |
| rst_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
A wrong counter value shows up within one cycle at the next counter read. It also shows up in the interrupt lines: they rise early or late relative to the programmed tick count. A status flag that is set or cleared wrongly is visible on irq_o at the same edge, because the interrupt lines reflect the flags directly. A watchdog enable bit that fails to clear shows up as a second reset pulse on the next channel-3 match, and as a nonzero readback of the watchdog enable register.

// File: rtl/ost_pkg.sv
package ost_pkg;
  typedef enum logic [2:0] {
    RS_NONE,
    RS_MATCH,
    RS_CNT,
    RS_STAT,
    RS_WDOG,
    RS_IEN
  } reg_sel_e;

  localparam int unsigned OFS_CNT  = 32'h10;
  localparam int unsigned OFS_STAT = 32'h14;
  localparam int unsigned OFS_WDOG = 32'h18;
  localparam int unsigned OFS_IEN  = 32'h1C;
endpackage

// File: rtl/ost_decode.sv
module ost_decode
  import ost_pkg::*;
#(
  parameter int unsigned AW  = 8,
  parameter int unsigned NCH = 4,
  parameter int unsigned IW  = 2
) (
  input  logic [AW-1:0] addr_i,
  output reg_sel_e      sel_o,
  output logic [IW-1:0] idx_o
);
  assign idx_o = addr_i[IW+1:2];

  always_comb begin
    sel_o = RS_NONE;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i < AW'(4 * NCH))        sel_o = RS_MATCH;
      else if (addr_i == AW'(OFS_CNT))  sel_o = RS_CNT;
      else if (addr_i == AW'(OFS_STAT)) sel_o = RS_STAT;
      else if (addr_i == AW'(OFS_WDOG)) sel_o = RS_WDOG;
      else if (addr_i == AW'(OFS_IEN))  sel_o = RS_IEN;
    end
  end
endmodule

// File: rtl/ost_counter.sv
module ost_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] nxt_o,
  output logic          inc_o
);
  logic [DW-1:0] cnt_q;

  assign nxt_o = cnt_q + DW'(1);
  assign inc_o = tick_i & ~ld_i;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (inc_o) cnt_q <= nxt_o;
  end
endmodule

// File: rtl/ost_match_bank.sv
module ost_match_bank #(
  parameter int unsigned DW  = 32,
  parameter int unsigned NCH = 4,
  parameter int unsigned IW  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [IW-1:0]           idx_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic                    inc_i,
  input  logic [DW-1:0]           nxt_i,
  input  logic [NCH-1:0]          en_i,
  input  logic                    clr_i,
  input  logic [NCH-1:0]          clr_mask_i,
  output logic [NCH-1:0][DW-1:0]  match_o,
  output logic [NCH-1:0]          hit_o,
  output logic [NCH-1:0]          stat_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] match_q;
    logic          stat_q;

    // compare against the post-increment value so one step = one event
    assign hit_o[g]   = inc_i && (nxt_i == match_q);
    assign match_o[g] = match_q;
    assign stat_o[g]  = stat_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        match_q <= '0;
        stat_q  <= 1'b0;
      end else begin
        if (wr_i && idx_i == IW'(g)) match_q <= wdata_i;
        if (hit_o[g] && en_i[g])     stat_q <= 1'b1;
        else if (clr_i && clr_mask_i[g]) stat_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ost_watchdog.sv
module ost_watchdog (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic fire_i,
  output logic en_o,
  output logic req_o
);
  logic en_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (fire_i && en_q) begin
        req_q <= 1'b1;
        en_q  <= 1'b0;
      end else if (wr_i) begin
        en_q <= wbit_i;
      end
    end
  end

  assign en_o  = en_q;
  assign req_o = req_q;
endmodule

// File: rtl/os_timer.sv
module os_timer
  import ost_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned NCH   = 4,
  parameter int unsigned AW    = 8,
  parameter int unsigned IEN_W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           sel_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           err_o,
  output logic [NCH-1:0] irq_o,
  output logic           rst_req_o
);
  localparam int unsigned IW    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned WD_CH = NCH - 1;

  reg_sel_e              rsel;
  logic [IW-1:0]         idx;
  logic                  wr;
  logic [DW-1:0]         cnt, nxt;
  logic                  inc;
  logic [NCH-1:0][DW-1:0] match;
  logic [NCH-1:0]        hit, stat;
  logic [IEN_W-1:0]      ien_q;
  logic                  wdog_en;
  logic [DW-1:0]         rd_mux, rdata_q;
  logic                  err_q;

  assign wr = sel_i & we_i;

  ost_decode #(.AW(AW), .NCH(NCH), .IW(IW)) u_dec (
    .addr_i(addr_i), .sel_o(rsel), .idx_o(idx)
  );

  ost_counter #(.DW(DW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .ld_i(wr && rsel == RS_CNT), .ld_val_i(wdata_i),
    .cnt_o(cnt), .nxt_o(nxt), .inc_o(inc)
  );

  ost_match_bank #(.DW(DW), .NCH(NCH), .IW(IW)) u_mb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr && rsel == RS_MATCH), .idx_i(idx), .wdata_i(wdata_i),
    .inc_i(inc), .nxt_i(nxt), .en_i(ien_q[NCH-1:0]),
    .clr_i(wr && rsel == RS_STAT), .clr_mask_i(wdata_i[NCH-1:0]),
    .match_o(match), .hit_o(hit), .stat_o(stat)
  );

  ost_watchdog u_wd (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr && rsel == RS_WDOG), .wbit_i(wdata_i[0]),
    .fire_i(hit[WD_CH]), .en_o(wdog_en), .req_o(rst_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ien_q <= '0;
    else if (wr && rsel == RS_IEN)   ien_q <= wdata_i[IEN_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    unique case (rsel)
      RS_MATCH: rd_mux = match[idx];
      RS_CNT:   rd_mux = cnt;
      RS_STAT:  rd_mux[NCH-1:0] = stat;
      RS_WDOG:  rd_mux[0] = wdog_en;
      RS_IEN:   rd_mux[IEN_W-1:0] = ien_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= sel_i && rsel == RS_NONE;
      if (sel_i && !we_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
  assign irq_o   = stat;
endmodule

// File: rtl/os_timer_chk.sv
module os_timer_chk
  import ost_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           tick_i,
  input logic           sel_i,
  input logic           we_i,
  input logic [AW-1:0]  addr_i,
  input logic [DW-1:0]  wdata_i,
  input logic [DW-1:0]  rdata_o,
  input logic           err_o,
  input logic [NCH-1:0] irq_o,
  input logic           rst_req_o,
  input logic [DW-1:0]  cnt_i,
  input logic [NCH-1:0] ien_i,
  input logic           wdog_en_i
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(tick_i) && !$past(sel_i && we_i && addr_i == AW'(OFS_CNT))
    |-> cnt_i == $past(cnt_i) + DW'(1));

  // R3
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(sel_i && we_i && addr_i == AW'(OFS_CNT))
    |-> cnt_i == $past(wdata_i));

  // R4
  irq_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && |(irq_o & ~$past(irq_o)) |-> $past(tick_i));

  // R5
  irq_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((irq_o & ~$past(irq_o) & ~$past(ien_i)) == '0));

  // R8
  req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R8
  req_disarms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !wdog_en_i);

  // R9
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && err_o |-> $past(sel_i));

  // R9
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && err_o && !$past(we_i) |-> rdata_o == '0);
endmodule

bind os_timer os_timer_chk #(.DW(DW), .NCH(NCH), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .sel_i(sel_i),
  .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .err_o(err_o), .irq_o(irq_o), .rst_req_o(rst_req_o), .cnt_i(cnt),
  .ien_i(ien_q[NCH-1:0]), .wdog_en_i(wdog_en)
);

// File: tb/sim_os_timer.sv
module sim_os_timer;
  localparam logic [7:0] A_CNT = 8'h10, A_STAT = 8'h14, A_WDOG = 8'h18, A_IEN = 8'h1C;

  typedef struct packed {
    logic [1:0]  ch;
    logic        en;
    logic [31:0] load;
    logic [31:0] mval;
    logic [7:0]  n;
    logic [3:0]  exp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 32'd10,         32'd13,  8'd3,  4'b0001},
    '{2'd1, 1'b1, 32'd10,         32'd13,  8'd2,  4'b0000},
    '{2'd2, 1'b1, 32'hFFFF_FFFE,  32'd0,   8'd2,  4'b0100},
    '{2'd3, 1'b0, 32'd100,        32'd102, 8'd5,  4'b0000},
    '{2'd1, 1'b1, 32'd5,          32'd6,   8'd10, 4'b0010},
    '{2'd3, 1'b1, 32'd0,          32'd1,   8'd1,  4'b1000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [3:0]  irq;
  logic        rst_req;

  int total = 0, fails = 0, pulses = 0;
  logic [31:0] rv;
  logic        re;

  always #10 clk = ~clk;

  os_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .irq_o(irq), .rst_req_o(rst_req)
  );

  always @(negedge clk) if (rst_req) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata; e = err;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(8'(4 * i), rv, re);
      chk("R1 reg", rv, 32'h0);
    end
    chk("R1 irq", {28'h0, irq}, 32'h0);
    chk("R1 rst_req", {31'h0, rst_req}, 32'h0);

    // R2 R3 load then count
    wr(A_CNT, 32'd50);
    ticks(3);
    rd(A_CNT, rv, re);
    chk("R2 count", rv, 32'd53);
    wr(A_CNT, 32'hFFFF_FFFF);
    ticks(1);
    rd(A_CNT, rv, re);
    chk("R2 wrap", rv, 32'd0);

    // R7 enable width
    wr(A_IEN, 32'hFFFF_FFFF);
    rd(A_IEN, rv, re);
    chk("R7 ien", rv, 32'h0000_0FFF);
    wr(A_IEN, 32'h0);

    // R4 R5 R10 vector walk
    foreach (VECS[i]) begin
      wr(A_STAT, 32'hF);
      wr(A_IEN, VECS[i].en ? (32'h1 << VECS[i].ch) : 32'h0);
      wr(8'(4 * VECS[i].ch), VECS[i].mval);
      wr(A_CNT, VECS[i].load);
      ticks(int'(VECS[i].n));
      rd(A_STAT, rv, re);
      chk("R4/R5 status", rv, {28'h0, VECS[i].exp});
      chk("R4 irq", {28'h0, irq}, {28'h0, VECS[i].exp});
    end
    wr(A_STAT, 32'hF);

    // R4 no repeat while counter holds
    wr(A_IEN, 32'h1);
    wr(8'h00, 32'd201);
    wr(A_CNT, 32'd200);
    ticks(1);
    rd(A_STAT, rv, re);
    chk("R4 event", rv, 32'h1);
    wr(A_STAT, 32'h1);
    repeat (5) @(negedge clk);
    rd(A_STAT, rv, re);
    chk("R4 once", rv, 32'h0);

    // R3 load equal to match does not fire
    wr(A_CNT, 32'd201);
    rd(A_STAT, rv, re);
    chk("R3 no fire", rv, 32'h0);

    // R6 selective clear
    wr(A_IEN, 32'h5);
    wr(8'h00, 32'd300);
    wr(8'h08, 32'd302);
    wr(A_CNT, 32'd299);
    ticks(3);
    rd(A_STAT, rv, re);
    chk("R6 both set", rv, 32'h5);
    wr(A_STAT, 32'h1);
    rd(A_STAT, rv, re);
    chk("R6 clear one", rv, 32'h4);
    chk("R6 irq", {28'h0, irq}, 32'h4);
    wr(A_STAT, 32'h0);
    wr(A_STAT, 32'hA);
    rd(A_STAT, rv, re);
    chk("R6 unchanged", rv, 32'h4);
    wr(A_STAT, 32'h4);
    rd(A_STAT, rv, re);
    chk("R6 cleared", rv, 32'h0);

    // R8 watchdog
    wr(A_IEN, 32'h0);
    wr(A_WDOG, 32'h1);
    rd(A_WDOG, rv, re);
    chk("R8 armed", rv, 32'h1);
    pulses = 0;
    wr(8'h0C, 32'd401);
    wr(A_CNT, 32'd400);
    ticks(1);
    repeat (2) @(negedge clk);
    chk("R8 one pulse", pulses, 32'd1);
    rd(A_WDOG, rv, re);
    chk("R8 disarmed", rv, 32'h0);
    rd(A_STAT, rv, re);
    chk("R5 ch3 masked", rv, 32'h0);
    wr(A_CNT, 32'd400);
    ticks(1);
    repeat (2) @(negedge clk);
    chk("R8 no rearm", pulses, 32'd1);

    // R9 unmapped access
    rd(8'h24, rv, re);
    chk("R9 data", rv, 32'h0);
    chk("R9 err", {31'h0, re}, 32'h1);
    @(negedge clk);
    chk("R9 err width", {31'h0, err}, 32'h0);
    rd(8'h02, rv, re);
    chk("R9 misaligned", {31'h0, re}, 32'h1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule